// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the fetch address for a small 8-bit controller. It holds an 11-bit program counter and moves it for each completed instruction. The counter can step to the next word, skip one word, or jump. It can also call, return, change only its low byte, or enter and leave the interrupt vector. The instruction decoder supplies a one-cycle step strobe, an operation code and a 9-bit operand field. The block keeps the three page bits of the status register. The jump and call targets are formed from those page bits plus the operand.

Calls push the return address onto an eight-entry hardware ring. Each entry also holds the page bits as they stood at the call. Plain returns pop only the address, and a cross-page return also puts back the saved page bits. A return-with-literal pops the address and presents an 8-bit literal, with a load strobe, for the working register. Interrupt entry keeps its return address in a one-word shadow register and leaves the ring alone.

Top module: `pc_seq`

## Requirements
- R1: After reset, the fetch address is 000h, the page bits are 000, and the working-register load strobe is low.
- R2: While the step input is low, the fetch address, the page bits and the ring stay unchanged, whatever the operation and operand inputs are.
- R3: Operation 0 (sequential) moves the address to address+1, and operation 1 (skip) moves it to address+2. Both wrap modulo 800h.
- R4: Operation 2 (jump) loads address bits 8:0 from operand bits 8:0, and address bits 10:9 from page bits 1:0.
- R5: Operation 3 (call) pushes the current address+1 together with the 3 page bits. It then loads address bits 7:0 from operand bits 7:0, forces bit 8 to 0, and takes bits 10:9 from page bits 1:0.
- R6: Operation 4 (return) loads the address from the newest ring entry, pops that entry, and leaves the page bits unchanged.
- R7: Operation 5 (cross-page return) pops like R6 and also restores the page bits that the popped entry saved at its call.
- R8: Operation 6 (return with literal) pops like R6. In the same cycle, the load strobe is high and the literal output equals operand bits 7:0. The strobe is low for every other operation and while step is low.
- R9: Operation 7 sets address bits 7:0 to operand bits 7:0. Operation 8 sets them to (address bits 7:0 + 1 + operand bits 7:0) mod 256. Both keep address bits 10:8.
- R10: Operation 9 (page select) writes operand bits 2:0 into the page bits and advances the address by one.
- R11: The ring holds 8 entries. A push onto a full ring overwrites the oldest entry. Each pop returns the entry at the ring pointer and moves the pointer back one slot, wrapping, with no error. So pops beyond the live entries return the older slot contents, which are 000h with page 000 after reset.
- R12: Operation 10 (interrupt) copies the current address into the shadow register and loads 000h. Operation 11 (interrupt return) loads the address from the shadow register. Neither operation touches the ring or the page bits. Codes 12 to 15 behave as operation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction completes this cycle |
| op | input | 4 | Operation code (see requirements) |
| arg | input | 9 | Operand field: target, literal or page value |
| pc | output | 11 | Next fetch address |
| page | output | 3 | Status page bits 7:5 (bits 6:5 feed the address) |
| w_load | output | 1 | Load the working register with w_lit this cycle |
| w_lit | output | 8 | Literal returned by a return-with-literal |

## Verification
The sweeps cover every jump operand under every page value and every low-byte operand for both low-byte forms. This would expose a design that took bits 10:9 from the wrong page bits, or that let the low-byte add carry into bit 8. Calls are checked with each page value, so a design that failed to clear bit 8 or that pushed the call address itself would be caught. Nested calls run ten deep and then return twelve times, so a design that refused pushes when full or stalled on an empty pop would return wrong addresses. Cross-page returns and interrupt round trips inside a call show whether the page bits are restored only where required and whether the shadow register is kept apart from the ring.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PCW   = 11,
  parameter int DEPTH = 8,
  parameter int PGW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [3:0]       op,
  input  logic [PCW-3:0]   arg,
  output logic [PCW-1:0]   pc,
  output logic [PGW-1:0]   page,
  output logic             w_load,
  output logic [PCW-4:0]   w_lit
);
  localparam int SPW = $clog2(DEPTH);
  localparam int JW  = PCW - 2;
  localparam int CW  = PCW - 3;
  localparam int EW  = PCW + PGW;

  localparam logic [3:0] OP_SEQ  = 4'd0;
  localparam logic [3:0] OP_SKIP = 4'd1;
  localparam logic [3:0] OP_JMP  = 4'd2;
  localparam logic [3:0] OP_CALL = 4'd3;
  localparam logic [3:0] OP_RET  = 4'd4;
  localparam logic [3:0] OP_RETP = 4'd5;
  localparam logic [3:0] OP_RETW = 4'd6;
  localparam logic [3:0] OP_LDLO = 4'd7;
  localparam logic [3:0] OP_ADLO = 4'd8;
  localparam logic [3:0] OP_PAGE = 4'd9;
  localparam logic [3:0] OP_IRQ  = 4'd10;
  localparam logic [3:0] OP_RETI = 4'd11;

  logic [PCW-1:0] pc_q, pc_d, sh_q;
  logic [PGW-1:0] pg_q, pg_d;
  logic [SPW-1:0] top_q;
  logic [EW-1:0]  stk [DEPTH];
  logic           push, pop;

  wire [PCW-1:0] inc1   = pc_q + 1'b1;
  wire [PCW-1:0] inc2   = pc_q + PCW'(2);
  wire [SPW-1:0] top_up = top_q + 1'b1;
  wire [SPW-1:0] top_dn = top_q - 1'b1;
  wire [EW-1:0]  tos    = stk[top_q];
  wire [CW-1:0]  lo_sum = pc_q[CW-1:0] + arg[CW-1:0] + 1'b1;

  always_comb begin
    pc_d = inc1;
    pg_d = pg_q;
    push = 1'b0;
    pop  = 1'b0;
    case (op)
      OP_SKIP: pc_d = inc2;
      OP_JMP:  pc_d = {pg_q[1:0], arg[JW-1:0]};
      OP_CALL: begin
        pc_d = {pg_q[1:0], 1'b0, arg[CW-1:0]};
        push = 1'b1;
      end
      OP_RET, OP_RETW: begin
        pc_d = tos[PCW-1:0];
        pop  = 1'b1;
      end
      OP_RETP: begin
        pc_d = tos[PCW-1:0];
        pg_d = tos[EW-1:PCW];
        pop  = 1'b1;
      end
      OP_LDLO: pc_d = {pc_q[PCW-1:CW], arg[CW-1:0]};
      OP_ADLO: pc_d = {pc_q[PCW-1:CW], lo_sum};
      OP_PAGE: pg_d = arg[PGW-1:0];
      OP_IRQ:  pc_d = '0;
      OP_RETI: pc_d = sh_q;
      default: pc_d = inc1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      pg_q  <= '0;
      sh_q  <= '0;
      top_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (step) begin
      pc_q <= pc_d;
      pg_q <= pg_d;
      if (op == OP_IRQ) sh_q <= pc_q;
      if (push) begin
        stk[top_up] <= {pg_q, inc1};
        top_q       <= top_up;
      end else if (pop) begin
        top_q <= top_dn;
      end
    end
  end

  assign pc     = pc_q;
  assign page   = pg_q;
  assign w_load = step && (op == OP_RETW);
  assign w_lit  = arg[CW-1:0];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(page));
  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == OP_SEQ |=> pc == $past(pc) + 1'b1);
  p_jmp_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == OP_JMP |=> pc[PCW-1:JW] == $past(page[1:0]));
  p_call_bit8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == OP_CALL |=> !pc[CW] && $stable(page));
  p_lo_segment_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step && (op == OP_LDLO || op == OP_ADLO) |=> pc[PCW-1:CW] == $past(pc[PCW-1:CW]));
  p_page_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == OP_PAGE |=> page == $past(arg[PGW-1:0]));
  p_irq_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == OP_IRQ |=> pc == '0 && $stable(page));
endmodule

// File: tb/pc_seq_tb.sv
module pc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [3:0] op = 4'd0;
  logic [8:0] arg = 9'd0;
  logic [10:0] pc;
  logic [2:0] page;
  logic w_load;
  logic [7:0] w_lit;

  int n_chk = 0;
  int n_bad = 0;

  int m_pc, m_pg, m_top, m_sh;
  int m_stk [8];

  always #2 clk = ~clk;

  pc_seq u_dut (.clk(clk), .rst_n(rst_n), .step(step), .op(op), .arg(arg),
                .pc(pc), .page(page), .w_load(w_load), .w_lit(w_lit));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(int o, int a);
    int v;
    case (o)
      1: m_pc = (m_pc + 2) % 2048;
      2: m_pc = (m_pg % 4) * 512 + a;
      3: begin
        m_top = (m_top + 1) % 8;
        m_stk[m_top] = m_pg * 2048 + (m_pc + 1) % 2048;
        m_pc = (m_pg % 4) * 512 + (a % 256);
      end
      4, 5, 6: begin
        v = m_stk[m_top];
        m_top = (m_top + 7) % 8;
        m_pc = v % 2048;
        if (o == 5) m_pg = v / 2048;
      end
      7: m_pc = (m_pc / 256) * 256 + (a % 256);
      8: m_pc = (m_pc / 256) * 256 + ((m_pc % 256) + 1 + (a % 256)) % 256;
      9: begin m_pg = a % 8; m_pc = (m_pc + 1) % 2048; end
      10: begin m_sh = m_pc; m_pc = 0; end
      11: m_pc = m_sh;
      default: m_pc = (m_pc + 1) % 2048;
    endcase
  endtask

  task automatic run(int o, int a, string tag);
    step = 1'b1;
    op = 4'(o);
    arg = 9'(a);
    #1;
    chk({tag, " w_load"}, w_load, (o == 6) ? 1 : 0);
    if (o == 6) chk("R8 w_lit", w_lit, a % 256);
    model(o, a);
    @(posedge clk);
    #1;
    chk({tag, " pc"}, pc, m_pc);
    chk({tag, " page"}, page, m_pg);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pc = 0; m_pg = 0; m_top = 0; m_sh = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pc", pc, 0);
    chk("R1 page", page, 0);
    chk("R1 w_load", w_load, 0);
    @(negedge clk);

    step = 1'b0; op = 4'd2; arg = 9'h1AB;
    repeat (3) @(negedge clk);
    chk("R2 pc", pc, 0);
    chk("R2 page", page, 0);
    op = 4'd6;
    #1;
    chk("R8 strobe idle", w_load, 0);
    @(negedge clk);
    op = 4'd3;
    @(negedge clk);
    run(4, 0, "R2 ring untouched");

    run(9, 3, "R10");
    run(2, 9'h1FE, "R4");
    run(0, 0, "R3 seq");
    run(0, 0, "R3 wrap");
    run(2, 9'h1FE, "R4");
    run(1, 0, "R3 skip wrap");
    run(1, 0, "R3 skip");
    for (int c = 12; c < 16; c++) run(c, 9'h155, "R12 spare code");

    for (int p = 0; p < 8; p++) begin
      run(9, p, "R10");
      for (int a = 0; a < 512; a++) run(2, a, "R4");
    end

    for (int p = 0; p < 8; p++) begin
      run(9, p, "R10");
      for (int a = 0; a < 256; a += 5) begin
        run(3, a + 256, "R5");
        run(4, 0, "R6");
      end
    end

    run(9, 2, "R10");
    run(2, 9'h044, "R4");
    run(3, 9'h0C0, "R5");
    run(9, 5, "R10");
    run(5, 0, "R7");
    run(9, 1, "R10");
    run(3, 9'h011, "R5");
    run(9, 6, "R10");
    run(4, 0, "R6 page kept");

    for (int a = 0; a < 256; a += 3) begin
      run(3, a, "R5");
      run(6, a ^ 8'h5A, "R8");
    end

    run(9, 3, "R10");
    run(2, 9'h0F3, "R4");
    for (int a = 0; a < 256; a++) begin
      run(8, a, "R9 add");
      run(7, a, "R9 load");
    end

    run(9, 0, "R10");
    for (int d = 0; d < 10; d++) begin
      run(9, d % 8, "R11 page");
      run(3, 16 * d + 3, "R11 push");
    end
    for (int d = 0; d < 12; d++) run(5, 0, "R11 pop");

    run(2, 9'h123, "R4");
    run(3, 9'h040, "R5");
    run(0, 0, "R3");
    run(10, 0, "R12 irq");
    run(3, 9'h077, "R12 call in isr");
    run(4, 0, "R12 ret in isr");
    run(11, 0, "R12 reti");
    run(4, 0, "R12 ring intact");

    step = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule